// File: doc/BRIEF.md
# Recently-Evicted Set Thrashing Detector

This block sits beside the miss handling logic of a data cache and watches for sets that keep losing their contents. It keeps a short ring of the set indices that were most recently evicted, with no data and no tags. When the cache reports a miss, the ring is searched for the missing set's index. If that set was evicted recently, the block emits a one-cycle request asking the cache to enable the expand bit for that set. The set is then a candidate for a second lookup in a partner set. The expand-bit storage and the cache arrays are outside this block.

The ring is touched only on misses, so the hit path of the cache carries no extra logic. A miss that also evicts a line writes its set index into the slot at the write pointer. That slot holds the oldest record, so the new index replaces it. The search on a given miss sees the ring as it stood before that miss's own write.

Both sides are plain strobes with no back-pressure. The cache presents at most one miss per cycle on `miss_valid`. It must take `expand_valid` in the cycle that signal is high, because the request is not held.

Top module: `evset_thrash_detect`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `expand_valid` is 0. Every ring slot is invalid after reset, and an invalid slot never matches, even for set index 0.
- R2: A cycle with `miss_valid`=1 whose `miss_set` equals a valid ring entry produces `expand_valid`=1 in the following cycle, with `expand_set` equal to that `miss_set`.
- R3: A miss whose set index is in no valid ring entry produces `expand_valid`=0 in the following cycle.
- R4: A cycle with `miss_valid`=0 produces `expand_valid`=0 in the following cycle, and `expand_set` is 0 whenever `expand_valid` is 0.
- R5: An index is recorded only in a cycle with both `miss_valid`=1 and `evict_valid`=1. A miss with `evict_valid`=0 leaves the ring unchanged.
- R6: `evict_valid`=1 without `miss_valid` has no effect on the ring.
- R7: The ring holds DEPTH entries (default 5, 8-bit indices). The write pointer advances by one per recorded eviction and wraps to zero after DEPTH-1. Once DEPTH further records have been made, a recorded index is overwritten and no longer matches.
- R8: The search on a miss uses the ring as it was before that miss's own record, so a first miss to a set never flags itself.
- R9: Each matching miss gives exactly one cycle of `expand_valid`. Consecutive matching misses give consecutive pulses, each carrying its own index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A cache miss is presented this cycle |
| miss_set | input | IDX_W | Set index of the miss |
| evict_valid | input | 1 | The miss also evicts a line from its set |
| expand_valid | output | 1 | One-cycle request to enable the expand bit |
| expand_set | output | IDX_W | Set whose expand bit is requested, 0 when idle |

## Verification
A stale or missing valid bit, or a write pointer that skips or wraps wrongly, cannot be seen until a later miss searches the ring. It then shows as a missing or spurious `expand_valid` one cycle after that miss. The sweeps therefore revisit sets at every distance from 1 to beyond DEPTH records. Each miss is compared in the cycle after it, so a corrupted entry is caught at its first reuse. Misses without eviction and evictions without misses are mixed in, so that a record made on the wrong qualifier shifts the ring and breaks later comparisons.

// File: rtl/evd_pkg.sv
package evd_pkg;
  typedef struct packed {
    logic       hit;
    logic [7:0] set;
  } evd_req8_t;

  function automatic int unsigned evd_ptr_w(input int unsigned depth);
    return (depth <= 2) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/evd_ring.sv
module evd_ring #(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned IDX_W = 8,
  localparam int unsigned PTR_W = evd_pkg::evd_ptr_w(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_set,
  output logic [DEPTH-1:0]            slot_vld,
  output logic [DEPTH-1:0][IDX_W-1:0] slot_set,
  output logic [PTR_W-1:0]            wr_ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
    end else if (wr_en) begin
      wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_ptr == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_vld[g] <= 1'b0;
        slot_set[g] <= '0;
      end else if (sel) begin
        slot_vld[g] <= 1'b1;
        slot_set[g] <= wr_set;
      end
    end
  end
endmodule

// File: rtl/evd_search.sv
module evd_search #(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned IDX_W = 8
) (
  input  logic                        enable,
  input  logic [IDX_W-1:0]            key,
  input  logic [DEPTH-1:0]            slot_vld,
  input  logic [DEPTH-1:0][IDX_W-1:0] slot_set,
  output logic                        found
);
  logic [DEPTH-1:0] eq;
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign eq[g] = slot_vld[g] && (slot_set[g] == key);
  end
  assign found = enable && (|eq);
endmodule

// File: rtl/evd_pulse.sv
module evd_pulse #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [IDX_W-1:0] fire_set,
  output logic             pulse,
  output logic [IDX_W-1:0] pulse_set
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse     <= 1'b0;
      pulse_set <= '0;
    end else begin
      pulse     <= fire;
      pulse_set <= fire ? fire_set : '0;
    end
  end
endmodule

// File: rtl/evset_thrash_detect.sv
module evset_thrash_detect #(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned IDX_W = 8,
  localparam int unsigned PTR_W = evd_pkg::evd_ptr_w(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  input  logic [IDX_W-1:0] miss_set,
  input  logic             evict_valid,
  output logic             expand_valid,
  output logic [IDX_W-1:0] expand_set
);
  logic                        rec_en;
  logic [DEPTH-1:0]            slot_vld;
  logic [DEPTH-1:0][IDX_W-1:0] slot_set;
  logic [PTR_W-1:0]            wr_ptr;
  logic                        found;

  assign rec_en = miss_valid && evict_valid;

  evd_ring #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_en(rec_en), .wr_set(miss_set),
    .slot_vld(slot_vld), .slot_set(slot_set), .wr_ptr(wr_ptr)
  );

  evd_search #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_search (
    .enable(miss_valid), .key(miss_set), .slot_vld(slot_vld),
    .slot_set(slot_set), .found(found)
  );

  evd_pulse #(.IDX_W(IDX_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(found), .fire_set(miss_set),
    .pulse(expand_valid), .pulse_set(expand_set)
  );
endmodule

// File: rtl/evd_checker.sv
module evd_checker #(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned PTR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             miss_valid,
  input logic [IDX_W-1:0] miss_set,
  input logic             evict_valid,
  input logic             expand_valid,
  input logic [IDX_W-1:0] expand_set,
  input logic [DEPTH-1:0] slot_vld,
  input logic [PTR_W-1:0] wr_ptr
);
  logic seen_clk;
  always_ff @(posedge clk) seen_clk <= 1'b1;

  // R1: no request in the cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    seen_clk && !$past(rst_n) |-> !expand_valid);

  // R2: a request always stems from a miss on the same set
  a_r2_req_from_miss: assert property (@(posedge clk) disable iff (!rst_n)
    expand_valid |-> $past(miss_valid) && expand_set == $past(miss_set));

  // R4: no miss, no request; idle index is zero
  a_r4_no_miss_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_valid |=> !expand_valid);
  a_r4_idle_set_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !expand_valid |-> expand_set == '0);

  // R5 / R6: ring only changes on a miss that evicts
  a_r5_ring_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(miss_valid && evict_valid) |=> $stable(slot_vld) && $stable(wr_ptr));

  // R7: pointer stays in range
  a_r7_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= PTR_W'(DEPTH - 1));

  // R8: an empty ring cannot match
  a_r8_empty_no_match: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld == '0) |=> !expand_valid);
endmodule

bind evset_thrash_detect evd_checker #(
  .DEPTH(DEPTH), .IDX_W(IDX_W), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_set(miss_set),
  .evict_valid(evict_valid), .expand_valid(expand_valid),
  .expand_set(expand_set), .slot_vld(slot_vld), .wr_ptr(wr_ptr)
);

// File: tb/tb_evset_thrash_detect.sv
module tb_evset_thrash_detect;
  localparam int DEPTH = 5;
  localparam int IDX_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             miss_valid = 1'b0;
  logic [IDX_W-1:0] miss_set = '0;
  logic             evict_valid = 1'b0;
  logic             expand_valid;
  logic [IDX_W-1:0] expand_set;

  int errors = 0;
  int checks = 0;

  int          m_vld [DEPTH];
  logic [7:0]  m_set [DEPTH];
  int          m_ptr;

  always #10 clk = ~clk;

  evset_thrash_detect #(.DEPTH(DEPTH), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_set(miss_set),
    .evict_valid(evict_valid), .expand_valid(expand_valid),
    .expand_set(expand_set)
  );

  task automatic check(input string req, input logic [IDX_W:0] act, input logic [IDX_W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: valid/set actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin m_vld[i] = 0; m_set[i] = '0; end
    m_ptr = 0;
  endtask

  // one cycle: drive at negedge, check result after next posedge
  task automatic step(input logic mv, input logic [7:0] s, input logic ev, input string req);
    logic hit;
    @(negedge clk);
    miss_valid = mv; miss_set = s; evict_valid = ev;
    hit = 1'b0;
    if (mv) for (int i = 0; i < DEPTH; i++) if (m_vld[i] != 0 && m_set[i] == s) hit = 1'b1;
    if (mv && ev) begin
      m_vld[m_ptr] = 1; m_set[m_ptr] = s;
      m_ptr = (m_ptr == DEPTH - 1) ? 0 : m_ptr + 1;
    end
    @(posedge clk); #5;
    check(req, {expand_valid, expand_set}, {hit, hit ? s : 8'h00});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; miss_valid = 1'b0; evict_valid = 1'b0; miss_set = '0;
    repeat (3) @(negedge clk);
    check("R1", {expand_valid, expand_set}, 9'h000);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lcg;
    do_reset();
    // R1 / R8: set 0 into empty ring, no self-match
    step(1, 8'h00, 1, "R1");
    step(1, 8'h00, 1, "R2");
    step(0, 8'h00, 0, "R4");
    // R3: unseen set
    step(1, 8'h99, 0, "R3");
    // R5: miss without evict does not record
    step(1, 8'h40, 0, "R5");
    step(1, 8'h40, 0, "R5");
    // R6: evict without miss ignored
    step(0, 8'h41, 1, "R6");
    step(1, 8'h41, 0, "R6");
    // R7: fill and overwrite
    do_reset();
    for (int i = 0; i < DEPTH; i++) step(1, 8'h10 + 8'(i), 1, "R8");
    step(1, 8'h20, 1, "R7");          // overwrites 0x10
    step(1, 8'h10, 0, "R7");          // gone
    step(1, 8'h11, 0, "R7");          // still present
    // R9: back-to-back matches
    step(1, 8'h12, 0, "R9");
    step(1, 8'h13, 0, "R9");
    step(1, 8'h20, 0, "R9");
    step(0, 8'h20, 0, "R9");
    // R2 / R7: near-exhaustive sweep over a small set space
    do_reset();
    lcg = 7;
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] s;
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      s = {lcg[20], 4'b0, lcg[18:16]};
      step(lcg[10:8] != 0, s, lcg[13:12] != 0, "R2");
    end
    // R7: every revisit distance against the wrap
    do_reset();
    for (int d = 1; d <= DEPTH + 2; d++) begin
      step(1, 8'hA0, 1, "R7");
      for (int k = 1; k < d; k++) step(1, 8'hB0 + 8'(k) + 8'(d * 16), 1, "R7");
      step(1, 8'hA0, 0, "R7");
      do_reset();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule